// File: doc/BRIEF.md
# Three-Button Mouse Packet Encoder

This block turns one motion-and-button event into a five-byte report for a three-button serial mouse and stores the report bytes in a 256-entry byte queue. A host drains the queue one byte at a time through a read port. The event side and the read side are both valid/ready streams. The clear input and the data lines are plain signals.

An event carries a signed horizontal delta, a signed vertical delta and three button levels. The event is accepted on a clock edge where `evt_valid` and `evt_ready` are both high. The source must hold `evt_valid` and the event fields steady until that edge. `evt_ready` stays low while a report is being written, so a second event waits until the first report is complete. Bytes that arrive while the queue is full are dropped without any indication.

On the read side, `rd_valid` is high whenever the queue holds a byte, and `rd_data` then shows the oldest byte. A byte is removed on a clock edge where `rd_valid` and `rd_ready` are both high. When the queue is empty, `rd_data` reads 0x00 and `rd_ready` has no effect.

Top module: `mouse_pkt_enc`

## Requirements
- R1: The first byte of every report is a sync byte equal to 0x87 with no buttons pressed. A pressed button clears one bit of it (active low): left (`evt_btn[2]`) clears bit 2, middle (`evt_btn[1]`) clears bit 1, right (`evt_btn[0]`) clears bit 0.
- R2: The second byte is the horizontal delta, limited to the range -127..+127 and encoded in 8-bit two's complement. Values above +127 give 0x7F, values below -127 give 0x81.
- R3: The third byte is the negated vertical delta, limited to -127..+127 in 8-bit two's complement. The negation happens before the limit, so an input of -128 yields 0x7F and an input of +127 yields 0x81.
- R4: The fourth and fifth bytes are always 0x00. The bytes leave the read port in the order sync, horizontal, vertical, zero, zero.
- R5: `evt_ready` is high when no report is being written. After an event is accepted, its five bytes are written on the five following clock edges and `evt_ready` is low during those cycles. An event held on `evt_valid` meanwhile is accepted on the first edge at which `evt_ready` is high again.
- R6: The queue holds 256 bytes. A byte that arrives while the queue is full is discarded, and the stored bytes and their order do not change.
- R7: `rd_valid` is high while the queue is not empty. `rd_data` shows the oldest byte, and a read removes exactly that byte.
- R8: When the queue is empty, `rd_valid` is low, `rd_data` is 0x00, and asserting `rd_ready` changes nothing.
- R9: A synchronous `clr` pulse empties the queue and abandons any report being written. After that edge, `rd_valid` is low and `evt_ready` is high.
- R10: After reset, `rd_valid` is low, `rd_data` is 0x00 and `evt_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of queue and packer |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event accepted when high with evt_valid |
| evt_dx | input | D_W | Signed horizontal delta |
| evt_dy | input | D_W | Signed vertical delta |
| evt_btn | input | 3 | Button levels: [2] left, [1] middle, [0] right |
| rd_valid | output | 1 | Queue holds a byte |
| rd_ready | input | 1 | Host takes the byte shown |
| rd_data | output | 8 | Oldest byte, 0x00 when empty |

## Verification
A wrong queue count or pointer shows up at the read port. It appears as a byte out of order, a repeated or missing byte, or `rd_valid` staying high after the last expected byte. Each of these is caught on the first read that reaches the damaged entry. A wrong slot counter in the packer makes `evt_ready` return early or late, which is visible in the cycle after the fifth write. It also shifts the zero padding, so the stream drifts against the expected bytes within one report. Clamp or negation errors appear directly in the second or third byte of the report that uses a boundary delta.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int BYTE_W  = 8;
  localparam int PKT_LEN = 5;
  localparam int SLOT_W  = $clog2(PKT_LEN);
  localparam logic [BYTE_W-1:0] SYNC_IDLE = 8'h87;
endpackage

// File: rtl/mpe_clamp.sv
module mpe_clamp #(
  parameter int IN_W   = 10,
  parameter bit NEGATE = 1'b0
) (
  input  logic [IN_W-1:0] din,
  output logic [7:0]      dout
);
  localparam logic signed [IN_W:0] LIM_HI = (IN_W+1)'(127);
  localparam logic signed [IN_W:0] LIM_LO = -(IN_W+1)'(127);

  logic signed [IN_W:0] ext;
  logic signed [IN_W:0] wide;

  assign ext = $signed({din[IN_W-1], din});

  generate
    if (NEGATE) begin : g_neg
      assign wide = -ext;
    end else begin : g_pass
      assign wide = ext;
    end
  endgenerate

  always_comb begin
    if (wide > LIM_HI)      dout = 8'h7F;
    else if (wide < LIM_LO) dout = 8'h81;
    else                    dout = wide[7:0];
  end
endmodule

// File: rtl/mpe_packer.sv
module mpe_packer
  import mpe_pkg::*;
#(
  parameter int D_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [D_W-1:0]    evt_dx,
  input  logic [D_W-1:0]    evt_dy,
  input  logic [2:0]        evt_btn,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_byte
);
  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic [BYTE_W-1:0] sync_q, x_q, y_q;
  logic [BYTE_W-1:0] x_c, y_c;
  logic              take;

  mpe_clamp #(.IN_W(D_W), .NEGATE(1'b0)) u_clamp_x (.din(evt_dx), .dout(x_c));
  mpe_clamp #(.IN_W(D_W), .NEGATE(1'b1)) u_clamp_y (.din(evt_dy), .dout(y_c));

  assign evt_ready = !busy;
  assign take      = evt_valid && !busy && !clr;
  assign wr_en     = busy && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= '0;
      sync_q <= SYNC_IDLE;
      x_q    <= '0;
      y_q    <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      slot   <= '0;
      sync_q <= SYNC_IDLE ^ {5'b0, evt_btn};
      x_q    <= x_c;
      y_q    <= y_c;
    end else if (busy) begin
      if (slot == SLOT_W'(PKT_LEN-1)) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  always_comb begin
    case (slot)
      SLOT_W'(0): wr_byte = sync_q;
      SLOT_W'(1): wr_byte = x_q;
      SLOT_W'(2): wr_byte = y_q;
      default:    wr_byte = '0;
    endcase
  end

  assert_write_follows_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && !clr) |=> wr_en);
  assert_sync_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && slot == '0) |-> (wr_byte[7:3] == 5'b10000));
  assert_busy_runs_five_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(clr)) |-> ($past(slot) == SLOT_W'(PKT_LEN-1)));
endmodule

// File: rtl/mpe_fifo.sv
module mpe_fifo
  import mpe_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     count;
  logic              full, do_rd, do_wr;

  assign full     = (count == CW'(DEPTH));
  assign rd_valid = (count != '0);
  assign do_rd    = rd_ready && rd_valid && !clr;
  assign do_wr    = wr_en && (!full || do_rd) && !clr;
  assign rd_data  = rd_valid ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_ready && !clr) |=> $stable(count));
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  assert_pop_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && rd_valid && !wr_en && !clr) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int D_W   = 10,
  parameter int DEPTH = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           evt_valid,
  output logic           evt_ready,
  input  logic [D_W-1:0] evt_dx,
  input  logic [D_W-1:0] evt_dy,
  input  logic [2:0]     evt_btn,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [7:0]     rd_data
);
  logic              wr_en;
  logic [BYTE_W-1:0] wr_byte;

  mpe_packer #(.D_W(D_W)) u_packer (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_dx(evt_dx), .evt_dy(evt_dy), .evt_btn(evt_btn),
    .wr_en(wr_en), .wr_byte(wr_byte)
  );

  mpe_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  assert_empty_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !wr_en && !clr) |=> (!rd_valid && rd_data == 8'h00));
endmodule

// File: tb/mouse_pkt_enc_bench.sv
`timescale 1ns/1ps
module mouse_pkt_enc_bench;
  localparam int D_W = 10;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic evt_valid = 1'b0, rd_ready = 1'b0;
  logic evt_ready, rd_valid;
  logic [D_W-1:0] evt_dx = '0, evt_dy = '0;
  logic [2:0] evt_btn = '0;
  logic [7:0] rd_data;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  byte unsigned q[$];

  always #5 clk = ~clk;

  mouse_pkt_enc #(.D_W(D_W), .DEPTH(256)) u_mouse_pkt_enc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_dx(evt_dx), .evt_dy(evt_dy), .evt_btn(evt_btn),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data));

  function automatic byte unsigned clamp8(int v);
    int s;
    s = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    return s[7:0];
  endfunction

  function automatic byte unsigned sync_of(logic [2:0] b);
    return 8'h87 ^ {5'b0, b};
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_push(int dx, int dy, logic [2:0] b);
    byte unsigned p[5];
    p[0] = sync_of(b); p[1] = clamp8(dx); p[2] = clamp8(-dy); p[3] = 0; p[4] = 0;
    foreach (p[i]) if (q.size() < 256) q.push_back(p[i]);
  endtask

  task automatic send_evt(int dx, int dy, logic [2:0] b);
    @(negedge clk);
    evt_dx = D_W'(dx); evt_dy = D_W'(dy); evt_btn = b; evt_valid = 1'b1;
    check("R5 ready idle", evt_ready, 1);
    @(negedge clk);
    evt_valid = 1'b0;
    check("R5 ready low busy", evt_ready, 0);
    repeat (5) @(negedge clk);
    check("R5 ready after five", evt_ready, 1);
    model_push(dx, dy, b);
  endtask

  task automatic read_one(string req);
    @(negedge clk);
    if (q.size() > 0) begin
      check({req, " valid"}, rd_valid, 1);
      check({req, " data"}, rd_data, q[0]);
      void'(q.pop_front());
    end else begin
      check("R8 empty valid", rd_valid, 0);
      check("R8 empty data", rd_data, 0);
    end
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic drain(string req);
    while (q.size() > 0) read_one(req);
    read_one("R8");
    @(negedge clk);
    check("R8 still empty", rd_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rd_valid", rd_valid, 0);
    check("R10 rd_data", rd_data, 0);
    check("R10 evt_ready", evt_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 read on empty ignored
    read_one("R8");
    // R1 buttons, R2/R3 boundaries, R4 padding
    send_evt(0, 0, 3'b000);
    send_evt(5, -7, 3'b100);
    send_evt(127, 127, 3'b010);
    send_evt(128, -128, 3'b001);
    send_evt(-127, -127, 3'b111);
    send_evt(-128, 128, 3'b101);
    send_evt(-512, 511, 3'b011);
    send_evt(511, -512, 3'b110);
    drain("R1 R2 R3 R4 R7");
    // R5 held event waits for previous report
    @(negedge clk);
    evt_dx = 10'd3; evt_dy = 10'd4; evt_btn = 3'b100; evt_valid = 1'b1;
    @(negedge clk);
    evt_dx = -10'sd9; evt_dy = 10'd200; evt_btn = 3'b001;
    repeat (4) begin
      check("R5 held not accepted", evt_ready, 0);
      @(negedge clk);
    end
    check("R5 held not accepted", evt_ready, 0);
    @(negedge clk);
    check("R5 held accepted", evt_ready, 1);
    @(negedge clk);
    evt_valid = 1'b0;
    check("R5 second busy", evt_ready, 0);
    repeat (5) @(negedge clk);
    model_push(3, 4, 3'b100);
    model_push(-9, 200, 3'b001);
    drain("R5 order");
    // R6 overflow: 52 events = 260 bytes, 4 dropped
    for (int i = 0; i < 52; i++) send_evt(i - 26, 26 - i, 3'(i));
    check("R6 count kept", q.size(), 256);
    repeat (3) @(negedge clk);
    check("R6 full valid", rd_valid, 1);
    drain("R6");
    // R9 clear mid-report
    @(negedge clk);
    evt_dx = 10'd1; evt_dy = 10'd1; evt_btn = 3'b000; evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R9 empty after clear", rd_valid, 0);
    check("R9 data zero", rd_data, 0);
    check("R9 ready after clear", evt_ready, 1);
    repeat (6) @(negedge clk);
    check("R9 no leftover bytes", rd_valid, 0);
    q.delete();
    // random mix
    for (int k = 0; k < 40; k++) begin
      int dx, dy;
      dx = int'($urandom_range(600)) - 300;
      dy = int'($urandom_range(600)) - 300;
      send_evt(dx, dy, 3'($urandom_range(7)));
      if ($urandom_range(3) == 0) drain("R2 R3 random");
    end
    drain("R7 random");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule